// File: doc/BRIEF.md
# Ternary Multi-Layer Pattern Matcher

This block is a small associative memory for track finding. Each stored pattern holds one super-bin value for each of eight physical detector layers. During an event, hit words arrive on eight parallel layer buses. Every hit is compared at once against the value that every pattern stores for that layer. When a hit agrees with a stored value, a sticky per-layer match latch is set. Each stored layer value carries a don't-care count that masks zero, one or two low bits, so each layer of each pattern matches at either fine or coarse resolution.

Physical layers 0 and 1 carry the same high-rate super bin, so together they form one logical layer: it counts as matched when either of the two matched. This gives seven logical layers. A pattern is a road when its matched logical-layer count reaches a programmable threshold and its disable bit is clear. The disable bits let defective patterns be masked, which recovers chips that have a few bad patterns.

On end-of-event the road set is captured and handed out in ascending pattern order over a valid/ready port. After that, every match latch is cleared, ready for the next event.

Top module: `tpm_matcher`

## Requirements
- R1: A load write (`ld_we_i`) stores `ld_bin_i` and `ld_dc_i` for pattern `ld_pat_i` and layer `ld_layer_i`. A pattern whose eight layers all receive their exact stored values in one event is reported as a road.
- R2: Don't-care count 0 requires all eight bits of a hit to equal the stored value, so a hit differing only in bit 0 does not match.
- R3: Don't-care count 1 ignores bit 0 of the comparison and still compares bit 1. Counts 2 and 3 both ignore bits 1:0.
- R4: Bit p of the disable register, written whole through `dis_we_i`/`dis_mask_i`, keeps pattern p from ever being reported. A disable write is ignored while `busy_o` is high. The register resets to all zeros.
- R5: Physical layers 0 and 1 form logical layer 0, which is matched if either physical layer matched. Physical layer k (k ≥ 2) forms logical layer k-1.
- R6: A pattern is a road when its matched logical-layer count is greater than or equal to the threshold register. That register is written through `thr_we_i` and resets to 7, the number of logical layers.
- R7: A match latch stays set for the rest of the event, even when later non-matching hits arrive. `evt_start_i` clears every latch, and hits presented in the same cycle as `evt_start_i` are dropped.
- R8: After `evt_end_i`, road indices appear on `road_idx_o` in strictly ascending order, one per cycle in which `road_valid_o` and `road_ready_i` are both high. While ready is low, valid and the index hold.
- R9: When the last road has been taken, `busy_o` stays high for one more cycle, in which all match latches are cleared. Hits presented while `busy_o` is high are ignored.
- R10: After reset, `road_valid_o` and `busy_o` are low. An end-of-event with no roads raises `busy_o` for exactly one cycle and produces no valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ld_we_i | input | 1 | Pattern layer write strobe |
| ld_pat_i | input | 3 | Pattern index for the write |
| ld_layer_i | input | 3 | Physical layer index for the write |
| ld_bin_i | input | 8 | Super-bin value to store |
| ld_dc_i | input | 2 | Don't-care low-bit count (0..3, 3 acts as 2) |
| dis_we_i | input | 1 | Disable register write strobe |
| dis_mask_i | input | 8 | New disable bits, one per pattern |
| thr_we_i | input | 1 | Threshold register write strobe |
| thr_i | input | 3 | New road threshold in logical layers |
| evt_start_i | input | 1 | Event start, clears match latches |
| evt_end_i | input | 1 | Event end, starts road readout |
| hit_vld_i | input | 8 | Per-layer hit valid |
| hit_bin_i | input | 64 | Per-layer hit value, layer k at bits 8k+7:8k |
| road_valid_o | output | 1 | Road index valid |
| road_idx_o | output | 3 | Index of the reported pattern |
| road_ready_i | input | 1 | Consumer accepts the road |
| busy_o | output | 1 | Readout in progress |

## Verification
The hardest state to reach from the ports is a single logical layer that is matched through only one of its two paired physical layers. Reaching it needs an event in which one paired bus is left silent while every other layer hits exactly, and then the opposite bus is left silent, with both cases producing the same road. The don't-care behaviour is reached with hits whose masked low bits are perturbed in turn, so the pattern that is programmed coarse on that layer matches while a fine pattern with the same perturbation does not. Latch clearing after readout is exposed by firing hits while the readout is stalled and then ending an empty event.

// File: rtl/tpm_pkg.sv
package tpm_pkg;
  typedef enum logic {RD_IDLE, RD_SCAN} rd_state_e;
  localparam int unsigned DC_MAX = 2;
endpackage

// File: rtl/tpm_layer_cell.sv
module tpm_layer_cell #(
  parameter int unsigned SB_W = 8,
  parameter int unsigned DC_W = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_i,
  input  logic [SB_W-1:0] wr_bin_i,
  input  logic [DC_W-1:0] wr_dc_i,
  input  logic            hit_vld_i,
  input  logic [SB_W-1:0] hit_bin_i,
  input  logic            clr_i,
  output logic            hit_q_o
);
  import tpm_pkg::*;

  logic [SB_W-1:0] bin_q;
  logic [DC_W-1:0] dc_q;
  logic [SB_W-1:0] cmp_mask;
  logic            agree;

  always_comb begin
    cmp_mask = '1;
    for (int b = 0; b < int'(DC_MAX); b++)
      if (int'(dc_q) > b) cmp_mask[b] = 1'b0;
    agree = ((hit_bin_i ^ bin_q) & cmp_mask) == '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bin_q <= '0;
      dc_q  <= '0;
    end else if (wr_i) begin
      bin_q <= wr_bin_i;
      dc_q  <= wr_dc_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  hit_q_o <= 1'b0;
    else if (clr_i)               hit_q_o <= 1'b0;
    else if (hit_vld_i && agree)  hit_q_o <= 1'b1;
  end

  p_latch_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_q_o && !clr_i |=> hit_q_o);
  p_latch_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !hit_q_o);
endmodule

// File: rtl/tpm_pattern.sv
module tpm_pattern #(
  parameter int unsigned SB_W     = 8,
  parameter int unsigned DC_W     = 2,
  parameter int unsigned NUM_PHYS = 8,
  parameter int unsigned LIDX_W   = $clog2(NUM_PHYS),
  parameter int unsigned CNT_W    = $clog2(NUM_PHYS)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_i,
  input  logic [LIDX_W-1:0]        wr_layer_i,
  input  logic [SB_W-1:0]          wr_bin_i,
  input  logic [DC_W-1:0]          wr_dc_i,
  input  logic [NUM_PHYS-1:0]      hit_vld_i,
  input  logic [NUM_PHYS*SB_W-1:0] hit_bin_i,
  input  logic                     clr_i,
  input  logic                     dis_i,
  input  logic [CNT_W-1:0]         thr_i,
  output logic                     road_o
);
  localparam int unsigned NUM_LOG = NUM_PHYS - 1;

  logic [NUM_PHYS-1:0] phys_hit;
  logic [NUM_LOG-1:0]  log_hit;
  logic [CNT_W-1:0]    cnt;

  for (genvar l = 0; l < NUM_PHYS; l++) begin : g_cell
    tpm_layer_cell #(.SB_W(SB_W), .DC_W(DC_W)) u_cell (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_i      (wr_i && (wr_layer_i == LIDX_W'(l))),
      .wr_bin_i  (wr_bin_i),
      .wr_dc_i   (wr_dc_i),
      .hit_vld_i (hit_vld_i[l]),
      .hit_bin_i (hit_bin_i[l*SB_W +: SB_W]),
      .clr_i     (clr_i),
      .hit_q_o   (phys_hit[l])
    );
  end

  // physical layers 0 and 1 share one high-rate super bin
  for (genvar k = 0; k < NUM_LOG; k++) begin : g_log
    if (k == 0) begin : g_pair
      assign log_hit[k] = phys_hit[0] | phys_hit[1];
    end else begin : g_single
      assign log_hit[k] = phys_hit[k+1];
    end
  end

  always_comb begin
    cnt = '0;
    for (int k = 0; k < int'(NUM_LOG); k++) cnt = cnt + CNT_W'(log_hit[k]);
  end

  assign road_o = !dis_i && (cnt >= thr_i);

  p_pair_or_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phys_hit[0] || phys_hit[1]) && !dis_i && thr_i == CNT_W'(1) |-> road_o);
endmodule

// File: rtl/tpm_readout.sv
module tpm_readout #(
  parameter int unsigned NUM_PAT = 8,
  parameter int unsigned PIDX_W  = $clog2(NUM_PAT)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [NUM_PAT-1:0] road_vec_i,
  input  logic               ready_i,
  output logic               valid_o,
  output logic [PIDX_W-1:0]  idx_o,
  output logic               busy_o,
  output logic               clr_o
);
  import tpm_pkg::*;

  rd_state_e          st_q;
  logic [NUM_PAT-1:0] pend_q;

  always_comb begin
    idx_o = '0;
    for (int i = int'(NUM_PAT) - 1; i >= 0; i--)
      if (pend_q[i]) idx_o = PIDX_W'(i);
  end

  assign busy_o  = (st_q == RD_SCAN);
  assign valid_o = busy_o && (pend_q != '0);
  assign clr_o   = busy_o && (pend_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= RD_IDLE;
      pend_q <= '0;
    end else if (st_q == RD_IDLE) begin
      if (start_i) begin
        st_q   <= RD_SCAN;
        pend_q <= road_vec_i;
      end
    end else if (pend_q == '0) begin
      st_q <= RD_IDLE;
    end else if (ready_i) begin
      pend_q[idx_o] <= 1'b0;
    end
  end

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i |=> valid_o && $stable(idx_o));
  p_ascend_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && ready_i |=> !valid_o || (idx_o > $past(idx_o)));
  p_clear_end_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_o |=> !busy_o);
endmodule

// File: rtl/tpm_matcher.sv
module tpm_matcher #(
  parameter int unsigned NUM_PAT  = 8,
  parameter int unsigned NUM_PHYS = 8,
  parameter int unsigned SB_W     = 8,
  parameter int unsigned DC_W     = 2,
  parameter int unsigned PIDX_W   = $clog2(NUM_PAT),
  parameter int unsigned LIDX_W   = $clog2(NUM_PHYS),
  parameter int unsigned CNT_W    = $clog2(NUM_PHYS)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     ld_we_i,
  input  logic [PIDX_W-1:0]        ld_pat_i,
  input  logic [LIDX_W-1:0]        ld_layer_i,
  input  logic [SB_W-1:0]          ld_bin_i,
  input  logic [DC_W-1:0]          ld_dc_i,
  input  logic                     dis_we_i,
  input  logic [NUM_PAT-1:0]       dis_mask_i,
  input  logic                     thr_we_i,
  input  logic [CNT_W-1:0]         thr_i,
  input  logic                     evt_start_i,
  input  logic                     evt_end_i,
  input  logic [NUM_PHYS-1:0]      hit_vld_i,
  input  logic [NUM_PHYS*SB_W-1:0] hit_bin_i,
  output logic                     road_valid_o,
  output logic [PIDX_W-1:0]        road_idx_o,
  input  logic                     road_ready_i,
  output logic                     busy_o
);
  localparam int unsigned NUM_LOG = NUM_PHYS - 1;

  logic [NUM_PAT-1:0]  dis_q;
  logic [CNT_W-1:0]    thr_q;
  logic [NUM_PAT-1:0]  road_vec;
  logic [NUM_PHYS-1:0] hit_en;
  logic                rd_clr;
  logic                lat_clr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dis_q <= '0;
      thr_q <= CNT_W'(NUM_LOG);
    end else begin
      if (dis_we_i && !busy_o) dis_q <= dis_mask_i;
      if (thr_we_i)            thr_q <= thr_i;
    end
  end

  assign hit_en  = (busy_o || evt_start_i) ? '0 : hit_vld_i;
  assign lat_clr = evt_start_i || rd_clr;

  for (genvar p = 0; p < NUM_PAT; p++) begin : g_pat
    tpm_pattern #(
      .SB_W(SB_W), .DC_W(DC_W), .NUM_PHYS(NUM_PHYS),
      .LIDX_W(LIDX_W), .CNT_W(CNT_W)
    ) u_pat (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_i       (ld_we_i && (ld_pat_i == PIDX_W'(p))),
      .wr_layer_i (ld_layer_i),
      .wr_bin_i   (ld_bin_i),
      .wr_dc_i    (ld_dc_i),
      .hit_vld_i  (hit_en),
      .hit_bin_i  (hit_bin_i),
      .clr_i      (lat_clr),
      .dis_i      (dis_q[p]),
      .thr_i      (thr_q),
      .road_o     (road_vec[p])
    );
  end

  tpm_readout #(.NUM_PAT(NUM_PAT), .PIDX_W(PIDX_W)) u_rd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (evt_end_i),
    .road_vec_i (road_vec),
    .ready_i    (road_ready_i),
    .valid_o    (road_valid_o),
    .idx_o      (road_idx_o),
    .busy_o     (busy_o),
    .clr_o      (rd_clr)
  );

  p_no_dis_road_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    road_valid_o |-> !dis_q[road_idx_o]);
  p_dis_frozen_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(dis_q));
endmodule

// File: tb/tpm_matcher_tb.sv
module tpm_matcher_tb;
  localparam int NP = 8;
  localparam int NL = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_we = 0;
  logic [2:0]  ld_pat = 0, ld_layer = 0;
  logic [7:0]  ld_bin = 0;
  logic [1:0]  ld_dc = 0;
  logic        dis_we = 0;
  logic [7:0]  dis_mask = 0;
  logic        thr_we = 0;
  logic [2:0]  thr = 0;
  logic        evt_start = 0, evt_end = 0;
  logic [7:0]  hit_vld = 0;
  logic [63:0] hit_bin = 0;
  logic        road_valid, road_ready = 1'b1, busy;
  logic [2:0]  road_idx;

  int n_chk = 0, n_bad = 0, cyc = 0;

  always #4 clk = ~clk;

  tpm_matcher u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .ld_we_i(ld_we), .ld_pat_i(ld_pat), .ld_layer_i(ld_layer),
    .ld_bin_i(ld_bin), .ld_dc_i(ld_dc),
    .dis_we_i(dis_we), .dis_mask_i(dis_mask),
    .thr_we_i(thr_we), .thr_i(thr),
    .evt_start_i(evt_start), .evt_end_i(evt_end),
    .hit_vld_i(hit_vld), .hit_bin_i(hit_bin),
    .road_valid_o(road_valid), .road_idx_o(road_idx),
    .road_ready_i(road_ready), .busy_o(busy)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog R8: act=hung exp=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  function automatic logic [7:0] bin_of(int p, int l);
    return {p[2:0], l[2:0], 2'b00};
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic load(input int p, input int l, input logic [7:0] b, input logic [1:0] dc);
    @(negedge clk);
    ld_we = 1; ld_pat = p[2:0]; ld_layer = l[2:0]; ld_bin = b; ld_dc = dc;
    @(negedge clk);
    ld_we = 0;
  endtask

  task automatic set_thr(input logic [2:0] t);
    @(negedge clk); thr_we = 1; thr = t;
    @(negedge clk); thr_we = 0;
  endtask

  task automatic set_dis(input logic [7:0] m);
    @(negedge clk); dis_we = 1; dis_mask = m;
    @(negedge clk); dis_we = 0;
  endtask

  task automatic start_evt();
    @(negedge clk); evt_start = 1;
    @(negedge clk); evt_start = 0;
  endtask

  task automatic send(input int tgt, input logic [7:0] skip, input int lowl, input logic [1:0] lowb);
    @(negedge clk);
    hit_vld = ~skip;
    for (int l = 0; l < NL; l++)
      hit_bin[l*8 +: 8] = bin_of(tgt, l) | ((l == lowl) ? {6'd0, lowb} : 8'd0);
    @(negedge clk);
    hit_vld = 0;
  endtask

  // end event, collect road indices with ready held high
  task automatic collect(input string tag, input logic [7:0] exp);
    logic [7:0] got;
    int last, guard;
    got = 0; last = -1; guard = 0;
    @(negedge clk); evt_end = 1;
    @(negedge clk); evt_end = 0;
    while (busy && guard < 20) begin
      if (road_valid) begin
        if (int'(road_idx) <= last) chk({tag, " R8 order"}, 8'(road_idx), 8'(last + 1));
        last = int'(road_idx);
        got[road_idx] = 1'b1;
      end
      guard++;
      @(negedge clk);
    end
    chk(tag, got, exp);
  endtask

  // {a,b_en,b,skip,lowl,lowb,thr,exp}
  localparam int NV = 13;
  localparam logic [30:0] VEC [NV] = '{
    {3'd1, 1'b0, 3'd0, 8'h00, 3'd0, 2'd0, 3'd7, 8'h02},  // R1 exact
    {3'd2, 1'b0, 3'd0, 8'h00, 3'd3, 2'd1, 3'd7, 8'h04},  // R3 dc1 bit0
    {3'd2, 1'b0, 3'd0, 8'h00, 3'd3, 2'd2, 3'd7, 8'h00},  // R3 dc1 bit1
    {3'd3, 1'b0, 3'd0, 8'h00, 3'd4, 2'd3, 3'd7, 8'h08},  // R3 dc2
    {3'd1, 1'b0, 3'd0, 8'h00, 3'd4, 2'd1, 3'd7, 8'h00},  // R2 fine
    {3'd4, 1'b0, 3'd0, 8'h01, 3'd0, 2'd0, 3'd7, 8'h10},  // R5 only phys1
    {3'd4, 1'b0, 3'd0, 8'h02, 3'd0, 2'd0, 3'd7, 8'h10},  // R5 only phys0
    {3'd4, 1'b0, 3'd0, 8'h03, 3'd0, 2'd0, 3'd7, 8'h00},  // R5 neither
    {3'd7, 1'b1, 3'd0, 8'h00, 3'd0, 2'd0, 3'd7, 8'h81},  // R8 two roads
    {3'd5, 1'b0, 3'd0, 8'h00, 3'd6, 2'd3, 3'd7, 8'h20},  // R3 dc3 as 2
    {3'd1, 1'b0, 3'd0, 8'h10, 3'd0, 2'd0, 3'd6, 8'h02},  // R6 at thr
    {3'd1, 1'b0, 3'd0, 8'h30, 3'd0, 2'd0, 3'd6, 8'h00},  // R6 below thr
    {3'd1, 1'b1, 3'd3, 8'h00, 3'd0, 2'd0, 3'd7, 8'h0A}   // R1 two patterns
  };

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 reset valid", {7'd0, road_valid}, 8'd0);
    chk("R10 reset busy", {7'd0, busy}, 8'd0);
    rst_n = 1'b1;

    for (int p = 0; p < NP; p++)
      for (int l = 0; l < NL; l++) begin
        logic [1:0] dc;
        dc = 2'd0;
        if (p == 2 && l == 3) dc = 2'd1;
        if (p == 3 && l == 4) dc = 2'd2;
        if (p == 5 && l == 6) dc = 2'd3;
        load(p, l, bin_of(p, l), dc);
      end

    // R10 empty readout: busy for one cycle, no valid
    @(negedge clk); evt_end = 1;
    @(negedge clk); evt_end = 0;
    chk("R10 empty busy", {7'd0, busy}, 8'd1);
    chk("R10 empty valid", {7'd0, road_valid}, 8'd0);
    @(negedge clk);
    chk("R10 empty done", {7'd0, busy}, 8'd0);

    for (int v = 0; v < NV; v++) begin
      logic [30:0] e;
      e = VEC[v];
      set_thr(e[10:8]);
      start_evt();
      send(int'(e[30:28]), e[23:16], int'(e[15:13]), e[12:11]);
      if (e[27]) send(int'(e[26:24]), e[23:16], int'(e[15:13]), e[12:11]);
      collect($sformatf("R%0d vec%0d", (v < 1 || v == 12) ? 1 : (v == 4 ? 2 :
              ((v >= 5 && v <= 7) ? 5 : (v == 8 ? 8 : (v >= 10 ? 6 : 3)))), v), e[7:0]);
    end
    set_thr(3'd7);

    // R4 disable
    set_dis(8'h40);
    start_evt(); send(6, 0, 0, 0); collect("R4 disabled alone", 8'h00);
    start_evt(); send(6, 0, 0, 0); send(1, 0, 0, 0); collect("R4 disabled with other", 8'h02);
    set_dis(8'h00);
    start_evt(); send(6, 0, 0, 0); collect("R4 re-enabled", 8'h40);

    // R7 sticky: matching hits, then mismatching hits on the same layers
    start_evt(); send(2, 0, 0, 0); send(1, 0, 0, 0);
    collect("R7 sticky", 8'h06);
    // R7 clear at event start
    start_evt(); send(2, 0, 0, 0); start_evt();
    collect("R7 cleared by start", 8'h00);
    // R7 hits in the start cycle dropped
    start_evt();
    @(negedge clk); evt_start = 1; hit_vld = 8'hFF;
    for (int l = 0; l < NL; l++) hit_bin[l*8 +: 8] = bin_of(3, l);
    @(negedge clk); evt_start = 0; hit_vld = 0;
    collect("R7 start-cycle hits", 8'h00);

    // R8 backpressure, R9 hits ignored while busy
    start_evt(); send(0, 0, 0, 0); send(7, 0, 0, 0);
    road_ready = 0;
    @(negedge clk); evt_end = 1;
    @(negedge clk); evt_end = 0;
    hit_vld = 8'hFF;
    for (int l = 0; l < NL; l++) hit_bin[l*8 +: 8] = bin_of(2, l);
    for (int k = 0; k < 3; k++) begin
      chk("R8 hold valid", {7'd0, road_valid}, 8'd1);
      chk("R8 hold idx", {5'd0, road_idx}, 8'd0);
      @(negedge clk);
    end
    road_ready = 1;
    @(negedge clk);
    chk("R8 next idx", {5'd0, road_idx}, 8'd7);
    @(negedge clk);
    chk("R9 final clear cycle", {6'd0, busy, road_valid}, 8'd2);
    hit_vld = 0;
    @(negedge clk);
    chk("R9 busy low", {7'd0, busy}, 8'd0);
    collect("R9 latches cleared, busy hits ignored", 8'h00);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule